// File: doc/BRIEF.md
# Relocatable Bus Address Resolver

This block turns a three-cell bus physical address (a high cell carrying flags and fields, a middle cell that must stay zero, and a low cell carrying the offset) into an absolute attach address plus an attach space for a device on a PCI-style bus. Addresses marked as fixed, and addresses in configuration space, are answered at once with the low cell unchanged. A relocatable I/O or memory address refers to one of the device's base registers. The block finds that register in a small table of assigned bases and adds the matching base to the offset.

The table is loaded through a simple write port, one slot at a time. A request is accepted when `req_valid` is high while `req_ready` is high. The block then either answers in the next cycle or walks the table one slot per cycle in index order. Each request ends in one `done` pulse that carries the space, the address and a single fault code. When several faults could apply, the first one found in the checking order is the one reported.

Top module: `addr_resolver`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `done` is 0 and every table slot is unused. A relocatable I/O request made then reports fault 5.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a table walk is running, and a `req_valid` raised during that time is ignored and produces no result.
- R3: A nonzero middle cell gives fault 1 (wide address unsupported), whatever the high cell holds. This check comes before every other one.
- R4: High-cell bit 31 set marks a fixed address. The result is then the low cell with fault 0. The space code in high-cell bits 25:24 (0 config, 1 I/O, 2 memory 32-bit, 3 memory 64-bit) gives the output space 0 config, 1 I/O, or 2 memory, and both memory codes give 2.
- R5: A relocatable address with space code 0 gives space 0, the low cell as the address, and fault 0, with no table walk.
- R6: A relocatable address with space code 3 gives fault 2 (relocatable wide memory unsupported).
- R7: A table write with `tbl_we` stores `tbl_used`, `tbl_hi` and `tbl_lo` into slot `tbl_idx`. The walk passes over an unused slot, but that slot still takes its cycle.
- R8: Early results (R3 to R6) make `done` high in the cycle just after the accepting edge. A walk decided at slot k makes `done` high k+1 cycles later than that.
- R9: A used slot whose high cell has bit 31 clear, or has register number (bits 7:0) zero, ends the walk with fault 3. This happens even when a later slot would match.
- R10: A used, well-formed slot whose register number equals the request's bits 7:0, but whose space code differs from the request's, ends the walk with fault 4.
- R11: A matching slot with the same space code ends the walk with fault 0. The address is the request's low cell plus the slot's low cell, modulo 2^32, and the space is 1 for I/O or 2 for memory.
- R12: A walk that reaches the last slot with no decision gives fault 5, with `done` N cycles later than an early result.
- R13: Every accepted request yields exactly one one-cycle `done` pulse. Whenever the fault is nonzero, `res_space` and `res_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_hi | input | 32 | High cell: fixed flag, space code, register number |
| req_mid | input | 32 | Middle cell, must be zero |
| req_lo | input | 32 | Low cell: offset or absolute address |
| tbl_we | input | 1 | Table slot write enable |
| tbl_idx | input | IDX_W | Slot index to write |
| tbl_used | input | 1 | Slot holds an assigned base |
| tbl_hi | input | 32 | Slot high cell |
| tbl_lo | input | 32 | Slot base address |
| done | output | 1 | One-cycle result strobe |
| res_space | output | 2 | Attach space: 0 config, 1 I/O, 2 memory |
| res_addr | output | 32 | Absolute attach address |
| res_err | output | 3 | Fault code 0 to 5 |

## Verification
The assertions assume that the request cells hold known values whenever `req_valid` is high. They also assume that the table does not change while a walk is running, because a slot rewritten mid-walk would decide a request against a mix of old and new contents. The stimulus writes table slots only while `req_ready` is high and no result is outstanding. It holds each request for exactly one accepting edge, and it raises `req_valid` during a walk only on purpose, to show that such a request is ignored.

// File: rtl/addr_resolve_pkg.sv
package addr_resolve_pkg;

    localparam int CELL_W    = 32;
    localparam int FIXED_BIT = 31;
    localparam int CODE_LSB  = 24;
    localparam int REGNO_W   = 8;

    typedef logic [CELL_W-1:0]  cell_t;
    typedef logic [REGNO_W-1:0] regno_t;

    typedef enum logic [1:0] {
        CODE_CFG   = 2'd0,
        CODE_IO    = 2'd1,
        CODE_MEM32 = 2'd2,
        CODE_MEM64 = 2'd3
    } space_code_e;

    typedef enum logic [1:0] {
        ATT_CFG = 2'd0,
        ATT_IO  = 2'd1,
        ATT_MEM = 2'd2
    } attach_space_e;

    // Fault codes; numbering is visible at the ports
    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_WIDE       = 3'd1,
        ERR_RELOC_WIDE = 3'd2,
        ERR_BAD_ENTRY  = 3'd3,
        ERR_TYPE_CLASH = 3'd4,
        ERR_NO_BASE    = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        STEP_SKIP,
        STEP_MISS,
        STEP_BAD,
        STEP_CLASH,
        STEP_HIT
    } step_e;

    typedef struct packed {
        logic        fixed;
        space_code_e code;
        regno_t      regno;
    } hi_view_t;

    typedef struct packed {
        logic  used;
        cell_t hi;
        cell_t lo;
    } base_entry_t;

    typedef struct packed {
        logic          done;
        attach_space_e space;
        cell_t         addr;
        fault_e        fault;
    } verdict_t;

    function automatic hi_view_t view_hi(cell_t hi);
        hi_view_t v;
        v.fixed = hi[FIXED_BIT];
        v.code  = space_code_e'(hi[CODE_LSB+1:CODE_LSB]);
        v.regno = hi[REGNO_W-1:0];
        return v;
    endfunction

    function automatic attach_space_e attach_of(space_code_e c);
        case (c)
            CODE_CFG: return ATT_CFG;
            CODE_IO:  return ATT_IO;
            default:  return ATT_MEM;
        endcase
    endfunction

    // Decisions that need no table walk, in priority order
    function automatic verdict_t early_verdict(cell_t hi, cell_t mid, cell_t lo);
        verdict_t v;
        hi_view_t h;
        h = view_hi(hi);
        v = '0;
        if (mid != '0) begin
            v.done = 1'b1; v.fault = ERR_WIDE;
        end else if (h.fixed) begin
            v.done = 1'b1; v.space = attach_of(h.code); v.addr = lo;
        end else if (h.code == CODE_CFG) begin
            v.done = 1'b1; v.space = ATT_CFG; v.addr = lo;
        end else if (h.code == CODE_MEM64) begin
            v.done = 1'b1; v.fault = ERR_RELOC_WIDE;
        end
        return v;
    endfunction

    function automatic step_e judge_entry(base_entry_t e, regno_t regno, space_code_e code);
        hi_view_t h;
        h = view_hi(e.hi);
        if (!e.used)                         return STEP_SKIP;
        if (!h.fixed || h.regno == '0)       return STEP_BAD;
        if (h.regno != regno)                return STEP_MISS;
        if (h.code != code)                  return STEP_CLASH;
        return STEP_HIT;
    endfunction

endpackage

// File: rtl/resolve_base_table.sv
module resolve_base_table
    import addr_resolve_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic              wused,
    input  cell_t             whi,
    input  cell_t             wlo,
    input  logic [IDX_W-1:0]  ridx,
    output base_entry_t       rentry
);

    base_entry_t slot_view [N_SLOTS];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        base_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                slot_q <= '{used: wused, hi: whi, lo: wlo};
            end
        end
        assign slot_view[g] = slot_q;
    end

    assign rentry = slot_view[ridx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (slot_view[$past(widx)].used == $past(wused)
                && slot_view[$past(widx)].hi == $past(whi)
                && slot_view[$past(widx)].lo == $past(wlo))); // R7

endmodule

// File: rtl/resolve_entry_check.sv
module resolve_entry_check
    import addr_resolve_pkg::*;
(
    input  base_entry_t entry,
    input  regno_t      regno,
    input  space_code_e code,
    output step_e       step
);

    always_comb step = judge_entry(entry, regno, code);

endmodule

// File: rtl/resolve_ctrl.sv
module resolve_ctrl
    import addr_resolve_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  cell_t            req_hi,
    input  cell_t            req_mid,
    input  cell_t            req_lo,
    input  step_e            step,
    input  cell_t            entry_lo,
    output logic [IDX_W-1:0] walk_idx,
    output regno_t           walk_regno,
    output space_code_e      walk_code,
    output logic             done,
    output attach_space_e    res_space,
    output cell_t            res_addr,
    output fault_e           res_err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

    typedef enum logic {PH_IDLE, PH_WALK} phase_e;

    phase_e            phase_q, phase_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    regno_t            regno_q;
    space_code_e       code_q;
    cell_t             lo_q;
    verdict_t          early, fin;
    hi_view_t          hv;
    logic              done_q;
    attach_space_e     space_q;
    cell_t             addr_q;
    fault_e            err_q;

    always_comb begin
        hv    = view_hi(req_hi);
        early = early_verdict(req_hi, req_mid, req_lo);
    end

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        fin     = '0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    if (early.done) begin
                        fin = early;
                    end else begin
                        phase_d = PH_WALK;
                        idx_d   = '0;
                    end
                end
            end
            default: begin
                case (step)
                    STEP_BAD:   fin = '{done: 1'b1, space: ATT_CFG, addr: '0, fault: ERR_BAD_ENTRY};
                    STEP_CLASH: fin = '{done: 1'b1, space: ATT_CFG, addr: '0, fault: ERR_TYPE_CLASH};
                    STEP_HIT:   fin = '{done: 1'b1, space: attach_of(code_q),
                                        addr: lo_q + entry_lo, fault: ERR_NONE};
                    default: begin
                        if (idx_q == LAST_IDX) begin
                            fin = '{done: 1'b1, space: ATT_CFG, addr: '0, fault: ERR_NO_BASE};
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                endcase
            end
        endcase
        if (fin.done) phase_d = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            regno_q <= '0;
            code_q  <= CODE_CFG;
            lo_q    <= '0;
            done_q  <= 1'b0;
            space_q <= ATT_CFG;
            addr_q  <= '0;
            err_q   <= ERR_NONE;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            done_q  <= fin.done;
            if (phase_q == PH_IDLE && req_valid && !early.done) begin
                regno_q <= hv.regno;
                code_q  <= hv.code;
                lo_q    <= req_lo;
            end
            if (fin.done) begin
                space_q <= fin.space;
                addr_q  <= fin.addr;
                err_q   <= fin.fault;
            end
        end
    end

    assign req_ready  = (phase_q == PH_IDLE);
    assign walk_idx   = idx_q;
    assign walk_regno = regno_q;
    assign walk_code  = code_q;
    assign done       = done_q;
    assign res_space  = space_q;
    assign res_addr   = addr_q;
    assign res_err    = err_q;

    AST_WIDE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mid != '0) |=> (done && res_err == ERR_WIDE)); // R3

    AST_FIXED_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mid == '0 && req_hi[FIXED_BIT])
        |=> (done && res_err == ERR_NONE && res_addr == $past(req_lo))); // R4

    AST_CFG_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mid == '0 && !req_hi[FIXED_BIT]
         && req_hi[CODE_LSB+1:CODE_LSB] == 2'd0)
        |=> (done && res_space == ATT_CFG && res_addr == $past(req_lo))); // R5

    AST_RELOC_WIDE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mid == '0 && !req_hi[FIXED_BIT]
         && req_hi[CODE_LSB+1:CODE_LSB] == 2'd3)
        |=> (done && res_err == ERR_RELOC_WIDE)); // R6

    AST_WALK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_mid == '0 && !req_hi[FIXED_BIT]
         && (req_hi[CODE_LSB+1:CODE_LSB] == 2'd1 || req_hi[CODE_LSB+1:CODE_LSB] == 2'd2))
        |=> (!done && !req_ready)); // R8

    AST_RESULT_FREES: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready); // R2

    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (done && res_err != ERR_NONE) |-> (res_space == ATT_CFG && res_addr == '0)); // R13

endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
    import addr_resolve_pkg::*;
#(
    parameter int  N_SLOTS = 8,
    localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_hi,
    input  logic [31:0]      req_mid,
    input  logic [31:0]      req_lo,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic             tbl_used,
    input  logic [31:0]      tbl_hi,
    input  logic [31:0]      tbl_lo,
    output logic             done,
    output logic [1:0]       res_space,
    output logic [31:0]      res_addr,
    output logic [2:0]       res_err
);

    logic [IDX_W-1:0] walk_idx;
    regno_t           walk_regno;
    space_code_e      walk_code;
    base_entry_t      cur_entry;
    step_e            step;
    attach_space_e    space_w;
    fault_e           err_w;

    resolve_base_table #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (tbl_we),
        .widx   (tbl_idx),
        .wused  (tbl_used),
        .whi    (tbl_hi),
        .wlo    (tbl_lo),
        .ridx   (walk_idx),
        .rentry (cur_entry)
    );

    resolve_entry_check u_check (
        .entry (cur_entry),
        .regno (walk_regno),
        .code  (walk_code),
        .step  (step)
    );

    resolve_ctrl #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_hi     (req_hi),
        .req_mid    (req_mid),
        .req_lo     (req_lo),
        .step       (step),
        .entry_lo   (cur_entry.lo),
        .walk_idx   (walk_idx),
        .walk_regno (walk_regno),
        .walk_code  (walk_code),
        .done       (done),
        .res_space  (space_w),
        .res_addr   (res_addr),
        .res_err    (err_w)
    );

    assign res_space = space_w;
    assign res_err   = err_w;

endmodule

// File: tb/tb_addr_resolver.sv
`timescale 1ns/1ps
module tb_addr_resolver;

    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_hi = '0, req_mid = '0, req_lo = '0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic          tbl_used = 1'b0;
    logic [31:0]   tbl_hi = '0, tbl_lo = '0;
    logic          done;
    logic [1:0]    res_space;
    logic [31:0]   res_addr;
    logic [2:0]    res_err;

    addr_resolver #(.N_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_hi(req_hi), .req_mid(req_mid), .req_lo(req_lo),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_used(tbl_used),
        .tbl_hi(tbl_hi), .tbl_lo(tbl_lo),
        .done(done), .res_space(res_space), .res_addr(res_addr), .res_err(res_err)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        string       tag;
        int          err;
        int          space;
        logic [31:0] addr;
        int          lat;
        int          acc;
    } exp_t;

    exp_t  sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    logic  m_used [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_lo [N];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(input bit fixed, input int code, input int dev,
                                       input int fn, input int regno);
        return {fixed, 5'b0, code[1:0], 8'h00, dev[4:0], fn[2:0], regno[7:0]};
    endfunction

    // Expected result from the requirements alone
    function automatic exp_t model(input logic [31:0] hi, mid, lo);
        exp_t e;
        int code;
        code = int'(hi[25:24]);
        e.tag = ""; e.err = 0; e.space = 0; e.addr = '0; e.lat = 0; e.acc = 0;
        if (mid != 0) begin e.tag = "R3 R13"; e.err = 1; return e; end
        if (hi[31]) begin
            e.tag = "R4"; e.space = (code >= 2) ? 2 : code; e.addr = lo; return e;
        end
        if (code == 0) begin e.tag = "R5"; e.addr = lo; return e; end
        if (code == 3) begin e.tag = "R6 R13"; e.err = 2; return e; end
        for (int k = 0; k < N; k++) begin
            if (!m_used[k]) continue;
            if (!m_hi[k][31] || m_hi[k][7:0] == 8'h00) begin
                e.tag = "R9 R8"; e.err = 3; e.lat = k + 1; return e;
            end
            if (m_hi[k][7:0] != hi[7:0]) continue;
            e.lat = k + 1;
            if (int'(m_hi[k][25:24]) != code) begin e.tag = "R10 R8"; e.err = 4; return e; end
            e.tag = "R11 R8"; e.space = (code == 1) ? 1 : 2; e.addr = lo + m_lo[k];
            return e;
        end
        e.tag = "R12"; e.err = 5; e.lat = N;
        return e;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each result strobe
    always @(negedge clk) begin
        if (!rst && done) begin
            checks++;
            if (sbq.size() == 0) begin
                failures++;
                $display("FAIL R2 R13 result with nothing outstanding actual err=%0d addr=%h expected none",
                         res_err, res_addr);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (int'(res_err) != e.err || int'(res_space) != e.space
                    || res_addr != e.addr || (cyc - e.acc) != e.lat) begin
                    failures++;
                    $display("FAIL %s actual err=%0d space=%0d addr=%h lat=%0d expected err=%0d space=%0d addr=%h lat=%0d",
                             e.tag, res_err, res_space, res_addr, cyc - e.acc,
                             e.err, e.space, e.addr, e.lat);
                end
            end
        end
    end

    task automatic send(input string tag, input logic [31:0] hi, mid, lo);
        exp_t e;
        while (!req_ready) @(negedge clk);
        e = model(hi, mid, lo);
        e.tag = {tag, " ", e.tag};
        e.acc = cyc + 1;
        sbq.push_back(e);
        req_valid = 1'b1; req_hi = hi; req_mid = mid; req_lo = lo;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // R7: slot write, mirrored into the bench model
    task automatic wr(input int idx, input bit used, input logic [31:0] hi, lo);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_used = used; tbl_hi = hi; tbl_lo = lo;
        @(negedge clk);
        tbl_we = 1'b0;
        m_used[idx] = used; m_hi[idx] = hi; m_lo[idx] = lo;
    endtask

    initial begin
        #750us;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin m_used[k] = 1'b0; m_hi[k] = '0; m_lo[k] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        send("R1 empty table", mk(0, 1, 2, 0, 'h10), 0, 'h20);
        drain();

        wr(0, 1, mk(1, 1, 2, 0, 'h14), 32'h0000_1000);
        wr(2, 1, mk(1, 2, 2, 0, 'h10), 32'h8000_1000);
        wr(3, 1, mk(1, 3, 2, 0, 'h18), 32'h0000_5000);

        send("R11 io slot0",        mk(0, 1, 2, 0, 'h14), 0, 'h20);          drain();
        send("R7 skip unused",      mk(0, 2, 2, 1, 'h10), 0, 'h4);           drain();
        send("R10 wide slot",       mk(0, 2, 2, 0, 'h18), 0, 'h8);           drain();
        send("R12 no match",        mk(0, 1, 2, 0, 'h24), 0, 'h0);           drain();
        send("R4 fixed io",         mk(1, 1, 5, 0, 'h00), 0, 'hABC);         drain();
        send("R4 fixed wide mem",   mk(1, 3, 5, 0, 'h00), 0, 32'hDEAD_0000); drain();
        send("R3 wide over fixed",  mk(1, 1, 5, 0, 'h00), 1, 'h10);          drain();
        send("R3 wide over reloc",  mk(0, 3, 5, 0, 'h10), 32'h10, 'h10);     drain();
        send("R5 config",           mk(0, 0, 3, 1, 'h00), 0, 'h40);          drain();
        send("R6 reloc wide",       mk(0, 3, 3, 0, 'h18), 0, 'h40);          drain();

        // R2: a request raised during a walk is dropped
        send("R2 long walk", mk(0, 1, 2, 0, 'h24), 0, 'h0);
        @(negedge clk);
        check(req_ready == 1'b0, "R2 ready during walk", int'(req_ready), 0);
        req_valid = 1'b1; req_hi = mk(1, 1, 0, 0, 0); req_mid = 0; req_lo = 'h77;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (3) @(negedge clk);

        wr(5, 1, mk(0, 1, 2, 0, 'h30), 32'h0000_9000);
        send("R9 reloc slot",       mk(0, 1, 2, 0, 'h24), 0, 'h0);           drain();
        send("R9 match before bad", mk(0, 1, 2, 0, 'h14), 0, 'h30);          drain();
        wr(4, 1, mk(1, 1, 2, 0, 'h00), 32'h0000_A000);
        send("R9 zero regno",       mk(0, 1, 2, 0, 'h24), 0, 'h0);           drain();
        wr(4, 0, '0, '0);
        wr(5, 0, '0, '0);
        wr(6, 1, mk(1, 1, 2, 0, 'h2C), 32'hFFFF_FFF0);
        send("R11 wrap add",        mk(0, 1, 2, 0, 'h2C), 0, 'h20);          drain();
        send("R12 after clears",    mk(0, 2, 2, 0, 'h24), 0, 'h0);           drain();

        // back-to-back early results: one pulse each
        send("R13 pair a", mk(1, 2, 0, 0, 0), 0, 'h100);
        send("R13 pair b", mk(0, 0, 1, 0, 0), 0, 'h200);
        drain();
        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R13 outstanding results", sbq.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule